// File: doc/BRIEF.md
# Lane-Column Operand Index Generator

The generator computes, for a vector operation of `LANES` output lanes and `COLS` columns, the buffer position of every operand that the multiplier array will read. Each lane takes its own 4-bit offset, which is added to a common start position. Each column then advances that position by a signed step. The result wraps inside a buffer whose sample count is a power of two. An X walk and a Y walk are produced together. The Y walk shares the per-lane offsets but has its own start and step, so a symmetric filter can read data forwards from X and backwards from Y.

When the Y step is not supplied, the Y walk uses the negated X step. All results are registered. A request on `vld_i` gives both index vectors one clock later, and the vectors hold their value until the next request.

Top module: `lane_idx_gen`

## Requirements
- R1: The flat output element e = r*COLS + c sits at bits [e*IDX_W +: IDX_W] of each index vector, so its lane is e / COLS and its column is e % COLS.
- R2: X element (r, c) equals (x_start + off[r] + x_step*c) mod 2^BUF_LOG2. Here x_step is a signed two's-complement value of STEP_W bits.
- R3: Lane r < 8 takes its offset off[r] from bits [4r+3:4r] of the low offset word, so lane 0 uses the least significant nibble. Offsets are unsigned.
- R4: Lane r in 8..15 takes its offset from bits [4(r-8)+3:4(r-8)] of the high offset word.
- R5: When `y_step_en_i` is 1, Y element (r, c) equals (y_start + off[r] + y_step*c) mod 2^BUF_LOG2.
- R6: When `y_step_en_i` is 0, the Y walk uses -x_step as its step and ignores `y_step_i`. This holds even for the most negative x_step.
- R7: Start values are signed, so a negative start or a negative step wraps back into the range 0 .. 2^BUF_LOG2-1.
- R8: `vld_o` is `vld_i` delayed by one cycle. Both index vectors change only in the cycle after `vld_i` was 1, and otherwise hold.
- R9: While `rst_ni` is low, `vld_o` and both index vectors are 0.
- R10: With start 0, per-lane offset equal to the lane number, and step 1, element (r, c) equals r + c (mod buffer size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Compute request |
| x_start_i | input | START_W | Signed X start position |
| offs_lo_i | input | 32 | Offsets of lanes 0..7, 4 bits each |
| offs_hi_i | input | 32 | Offsets of lanes 8..15, 4 bits each |
| x_step_i | input | STEP_W | Signed X column step |
| y_start_i | input | START_W | Signed Y start position |
| y_step_i | input | STEP_W | Signed Y column step |
| y_step_en_i | input | 1 | 1: use y_step_i; 0: use -x_step_i |
| vld_o | output | 1 | Index vectors updated this cycle |
| x_idx_o | output | LANES*COLS*IDX_W | X indices, element e at [e*IDX_W +: IDX_W] |
| y_idx_o | output | LANES*COLS*IDX_W | Y indices, same packing |

## Verification
The bench uses the defaults: 16 lanes, 2 columns, a 32-sample buffer, a 6-bit step and a 32-bit start. Sixteen lanes are needed so that the high offset word is actually decoded and the low/high split at lane 8 can be checked. A 32-sample buffer makes wrap-around easy to provoke, both with negative starts and with large offset and step sums. A 6-bit step lets the mirrored Y walk meet the -32 step, whose negation does not fit in the step width.

// File: rtl/lane_idx_pkg.sv
package lane_idx_pkg;
  localparam int NIB_W      = 4;
  localparam int WORD_W     = 32;
  localparam int WORD_LANES = WORD_W / NIB_W;
  localparam int MAX_LANES  = 2 * WORD_LANES;
endpackage

// File: rtl/lane_offs_unpack.sv
module lane_offs_unpack
  import lane_idx_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [WORD_W-1:0]      lo_i,
  input  logic [WORD_W-1:0]      hi_i,
  output logic [LANES*NIB_W-1:0] offs_o
);
  for (genvar r = 0; r < LANES; r++) begin : g_lane
    if (r < WORD_LANES) begin : g_lo
      assign offs_o[r*NIB_W +: NIB_W] = lo_i[r*NIB_W +: NIB_W];
    end else begin : g_hi
      assign offs_o[r*NIB_W +: NIB_W] = hi_i[(r-WORD_LANES)*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/lane_idx_ystep.sv
module lane_idx_ystep #(
  parameter int STEP_W = 6,
  localparam int YW    = STEP_W + 1
) (
  input  logic signed [STEP_W-1:0] x_step_i,
  input  logic signed [STEP_W-1:0] y_step_i,
  input  logic                     y_step_en_i,
  output logic signed [YW-1:0]     y_step_o
);
  // one extra bit so that negating the most negative step cannot overflow
  logic signed [YW-1:0] x_ext, y_ext;
  assign x_ext    = YW'(x_step_i);
  assign y_ext    = YW'(y_step_i);
  assign y_step_o = y_step_en_i ? y_ext : -x_ext;
endmodule

// File: rtl/lane_idx_walk.sv
module lane_idx_walk
  import lane_idx_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int COLS    = 2,
  parameter int IDX_W   = 5,
  parameter int START_W = 32,
  parameter int STEP_W  = 6,
  localparam int NE     = LANES * COLS
) (
  input  logic signed [START_W-1:0]  start_i,
  input  logic signed [STEP_W-1:0]   step_i,
  input  logic [LANES*NIB_W-1:0]     offs_i,
  output logic [NE*IDX_W-1:0]        idx_o
);
  logic [IDX_W-1:0] base, stp;
  logic [IDX_W-1:0] lane_base [LANES];
  logic [IDX_W-1:0] col_ofs   [COLS];

  // buffer size is a power of two: modulo is truncation to IDX_W bits
  assign base = IDX_W'(start_i);
  assign stp  = IDX_W'(step_i);

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    assign lane_base[r] = base + IDX_W'(offs_i[r*NIB_W +: NIB_W]);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_ofs[c] = stp * IDX_W'(c);
  end

  for (genvar r = 0; r < LANES; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      assign idx_o[(r*COLS+c)*IDX_W +: IDX_W] = lane_base[r] + col_ofs[c];
    end
  end
endmodule

// File: rtl/lane_idx_gen.sv
module lane_idx_gen
  import lane_idx_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int COLS     = 2,
  parameter int BUF_LOG2 = 5,
  parameter int START_W  = 32,
  parameter int STEP_W   = 6,
  localparam int IDX_W   = BUF_LOG2,
  localparam int NE      = LANES * COLS,
  localparam int VEC_W   = NE * IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic signed [START_W-1:0] x_start_i,
  input  logic [WORD_W-1:0]         offs_lo_i,
  input  logic [WORD_W-1:0]         offs_hi_i,
  input  logic signed [STEP_W-1:0]  x_step_i,
  input  logic signed [START_W-1:0] y_start_i,
  input  logic signed [STEP_W-1:0]  y_step_i,
  input  logic                      y_step_en_i,
  output logic                      vld_o,
  output logic [VEC_W-1:0]          x_idx_o,
  output logic [VEC_W-1:0]          y_idx_o
);
  logic [LANES*NIB_W-1:0]  offs;
  logic signed [STEP_W:0]  y_step;
  logic [VEC_W-1:0]        x_d, y_d, x_q, y_q;
  logic                    vld_q;

  lane_offs_unpack #(.LANES(LANES)) u_unpack (
    .lo_i(offs_lo_i), .hi_i(offs_hi_i), .offs_o(offs)
  );

  lane_idx_ystep #(.STEP_W(STEP_W)) u_ystep (
    .x_step_i(x_step_i), .y_step_i(y_step_i),
    .y_step_en_i(y_step_en_i), .y_step_o(y_step)
  );

  lane_idx_walk #(
    .LANES(LANES), .COLS(COLS), .IDX_W(IDX_W), .START_W(START_W), .STEP_W(STEP_W)
  ) u_xwalk (
    .start_i(x_start_i), .step_i(x_step_i), .offs_i(offs), .idx_o(x_d)
  );

  lane_idx_walk #(
    .LANES(LANES), .COLS(COLS), .IDX_W(IDX_W), .START_W(START_W), .STEP_W(STEP_W+1)
  ) u_ywalk (
    .start_i(y_start_i), .step_i(y_step), .offs_i(offs), .idx_o(y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        x_q <= x_d;
        y_q <= y_d;
      end
    end
  end

  assign vld_o   = vld_q;
  assign x_idx_o = x_q;
  assign y_idx_o = y_q;
endmodule

// File: rtl/lane_idx_gen_chk.sv
module lane_idx_gen_chk #(
  parameter int COLS    = 2,
  parameter int IDX_W   = 5,
  parameter int START_W = 32,
  parameter int STEP_W  = 6,
  parameter int VEC_W   = 160
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      vld_i,
  input logic signed [START_W-1:0] x_start_i,
  input logic signed [START_W-1:0] y_start_i,
  input logic signed [STEP_W-1:0]  x_step_i,
  input logic                      y_step_en_i,
  input logic [3:0]                lane0_off_i,
  input logic                      vld_o,
  input logic [VEC_W-1:0]          x_idx_o,
  input logic [VEC_W-1:0]          y_idx_o
);
  p_reset_state_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!vld_o && x_idx_o == '0 && y_idx_o == '0));

  p_vld_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);

  p_vld_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(x_idx_o) && $stable(y_idx_o)));

  p_lane0_x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> x_idx_o[IDX_W-1:0] ==
      IDX_W'(IDX_W'($past(x_start_i)) + IDX_W'($past(lane0_off_i))));

  p_lane0_y_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> y_idx_o[IDX_W-1:0] ==
      IDX_W'(IDX_W'($past(y_start_i)) + IDX_W'($past(lane0_off_i))));

  if (COLS > 1) begin : g_cols
    p_col_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_i |=> IDX_W'(x_idx_o[IDX_W +: IDX_W] - x_idx_o[0 +: IDX_W]) ==
        IDX_W'($past(x_step_i)));

    p_mirror_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !y_step_en_i) |=>
        IDX_W'((y_idx_o[IDX_W +: IDX_W] - y_idx_o[0 +: IDX_W]) +
               (x_idx_o[IDX_W +: IDX_W] - x_idx_o[0 +: IDX_W])) == IDX_W'(0));
  end
endmodule

bind lane_idx_gen lane_idx_gen_chk #(
  .COLS(COLS), .IDX_W(IDX_W), .START_W(START_W), .STEP_W(STEP_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i),
  .x_start_i(x_start_i), .y_start_i(y_start_i), .x_step_i(x_step_i),
  .y_step_en_i(y_step_en_i), .lane0_off_i(offs_lo_i[3:0]),
  .vld_o(vld_o), .x_idx_o(x_idx_o), .y_idx_o(y_idx_o)
);

// File: tb/sim_lane_idx_gen.sv
module sim_lane_idx_gen;
  localparam int L = 16, C = 2, IW = 5, NE = L*C;

  logic clk = 1'b0, rst_ni = 1'b0, vld_i = 1'b0, y_step_en_i = 1'b0;
  logic signed [31:0] x_start_i = '0, y_start_i = '0;
  logic [31:0] offs_lo_i = '0, offs_hi_i = '0;
  logic signed [5:0] x_step_i = '0, y_step_i = '0;
  logic vld_o;
  logic [NE*IW-1:0] x_idx_o, y_idx_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_idx_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .x_start_i(x_start_i),
    .offs_lo_i(offs_lo_i), .offs_hi_i(offs_hi_i), .x_step_i(x_step_i),
    .y_start_i(y_start_i), .y_step_i(y_step_i), .y_step_en_i(y_step_en_i),
    .vld_o(vld_o), .x_idx_o(x_idx_o), .y_idx_o(y_idx_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_off(input logic [31:0] lo, input logic [31:0] hi, input int r);
    return (r < 8) ? int'(lo[r*4 +: 4]) : int'(hi[(r-8)*4 +: 4]);
  endfunction

  function automatic int xel(input int e);
    return int'(x_idx_o[e*IW +: IW]);
  endfunction

  function automatic int yel(input int e);
    return int'(y_idx_o[e*IW +: IW]);
  endfunction

  task automatic apply(input int xs, input logic [31:0] lo, input logic [31:0] hi,
                       input int xst, input int ys, input int yst, input bit yen);
    @(negedge clk);
    x_start_i = xs; offs_lo_i = lo; offs_hi_i = hi; x_step_i = 6'(xst);
    y_start_i = ys; y_step_i = 6'(yst); y_step_en_i = yen; vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  // compare every element against the formula of R2 and R5
  task automatic cmp_all(input string req, input int xs, input logic [31:0] lo,
                         input logic [31:0] hi, input int xst, input int ys, input int yst_eff);
    for (int r = 0; r < L; r++) begin
      for (int c = 0; c < C; c++) begin
        chk({req, " x"}, xel(r*C+c), (xs + lane_off(lo, hi, r) + xst*c) & 31);
        chk({req, " y"}, yel(r*C+c), (ys + lane_off(lo, hi, r) + yst_eff*c) & 31);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 vld_o", int'(vld_o), 0);
    chk("R9 x_idx", int'(x_idx_o != '0), 0);
    chk("R9 y_idx", int'(y_idx_o != '0), 0);
  endtask

  task automatic t_example();
    apply(0, 32'h7654_3210, 32'hFEDC_BA98, 1, 0, 1, 1'b1);
    chk("R8 vld_o", int'(vld_o), 1);
    for (int r = 0; r < L; r++)
      for (int c = 0; c < C; c++)
        chk("R10 R1 r+c", xel(r*C+c), (r + c) % 32);
    cmp_all("R2", 0, 32'h7654_3210, 32'hFEDC_BA98, 1, 0, 1);
  endtask

  task automatic t_offsets();
    apply(4, 32'h1F2E_3D4C, 32'h89AB_CDE5, 7, 9, -2, 1'b1);
    chk("R3 lane0", xel(0), 4 + 4'hC);
    chk("R3 lane1", xel(1*C), 4 + 4'h4);
    chk("R4 lane8", xel(8*C), 4 + 4'h5);
    chk("R4 lane15", xel(15*C), 4 + 4'h8);
    cmp_all("R5", 4, 32'h1F2E_3D4C, 32'h89AB_CDE5, 7, 9, -2);
  endtask

  task automatic t_negative();
    apply(-3, 32'h0, 32'h0, -5, -40, 3, 1'b1);
    chk("R7 lane0 c0", xel(0), 29);
    chk("R7 lane0 c1", xel(1), 24);
    chk("R7 y c0", yel(0), 24);
    cmp_all("R7", -3, 32'h0, 32'h0, -5, -40, 3);
  endtask

  task automatic t_mirror();
    apply(10, 32'h0123_4567, 32'hA5A5_5A5A, 3, 20, 7, 1'b0);
    chk("R6 y c1", yel(1), (20 + 7 - 3) & 31);
    cmp_all("R6", 10, 32'h0123_4567, 32'hA5A5_5A5A, 3, 20, -3);
    apply(1, 32'h0, 32'hFFFF_FFFF, -32, 5, 11, 1'b0);
    cmp_all("R6 min step", 1, 32'h0, 32'hFFFF_FFFF, -32, 5, 32);
  endtask

  task automatic t_hold();
    logic [NE*IW-1:0] xs, ys;
    apply(6, 32'h1111_2222, 32'h3333_4444, 2, 8, 1, 1'b1);
    xs = x_idx_o; ys = y_idx_o;
    x_start_i = 17; offs_lo_i = 32'hFFFF_FFFF; x_step_i = 6'd9; y_start_i = 3;
    repeat (3) @(negedge clk);
    chk("R8 vld low", int'(vld_o), 0);
    chk("R8 x held", int'(x_idx_o == xs), 1);
    chk("R8 y held", int'(y_idx_o == ys), 1);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_example();
    t_offsets();
    t_negative();
    t_mirror();
    t_hold();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule